// File: doc/BRIEF.md
# Cascadable Prescaled Timer Bank

This block holds four 16-bit up-counters that share one clock. Each counter has its own reload value and control word. A counter either advances on a divided clock tick, using one of four divide ratios, or, for every counter except the first, advances once for each overflow of the counter just below it. Chaining counters this way builds intervals far longer than one 16-bit counter can span.

Reload values and control words are written through a single-cycle write port. Any counter's live value can be read back through a combinational read mux. Each counter drives one interrupt request bit. That bit pulses for one cycle after the counter overflows, provided its interrupt enable is set. Bus decoding and interrupt collection are left to the surrounding logic. In a system, bit `t` of `irq` feeds interrupt line 3 + t.

Top module: `tmr_bank`

## Requirements
- R1: After reset every counter reads 0, every counter is disabled and `irq` is all zero.
- R2: A write with `wr_ctl`=0 stores `wr_data` as the reload value of timer `wr_idx`. A write with `wr_ctl`=1 stores its control word, which has these fields: bits [1:0] prescale code, bit 2 cascade select, bit 6 interrupt enable, bit 7 run enable.
- R3: Changing the run enable from 0 to 1 loads the reload value into the counter at the write edge and restarts the prescaler, so the first increment lands 2^shift edges later.
- R4: In prescaled mode an enabled counter advances by one every 2^shift clock edges. Prescale codes 0, 1, 2 and 3 select shifts 0, 6, 8 and 10.
- R5: When a counter at 0xFFFF advances, it overflows and loads its reload value plus the excess past the wrap. With single steps the excess is zero.
- R6: An overflow raises `irq[t]` for exactly the following cycle when interrupt enable is set. When interrupt enable is clear, `irq[t]` stays 0.
- R7: A timer t>0 with cascade select set advances only on an edge where timer t-1 overflows, in that same edge. A double overflow down the chain therefore completes in one cycle.
- R8: Timer 0 ignores cascade select and always counts prescaled ticks.
- R9: A disabled counter holds its value. Writing a new reload value while a counter runs does not change the count until the next overflow.
- R10: `rd_count` shows the current count of timer `rd_idx` in the same cycle.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_en | input | 1 | Write strobe, one cycle per write |
| wr_idx | input | 2 | Timer addressed by the write |
| wr_ctl | input | 1 | 1 selects the control word, 0 the reload value |
| wr_data | input | 16 | Write data |
| rd_idx | input | 2 | Timer whose count is shown on rd_count |
| rd_count | output | 16 | Current count of the selected timer |
| irq | output | 4 | Per-timer overflow interrupt pulse |

## Verification
The bench builds the block with its default parameters: four timers, 16-bit counters, a 10-bit prescaler and shifts 0/6/8/10. Reload values just below 0xFFFF bring overflows, reload on wrap and the two-level cascade within a few cycles. The divide-by-64 and divide-by-1024 settings stay short enough to check their exact tick edges and a full overflow period. Expected counts come from a closed-form model of reload, shift and elapsed edges.

// File: rtl/tmr_pkg.sv
package tmr_pkg;

  localparam int CB_PSC  = 0;
  localparam int CB_CASC = 2;
  localparam int CB_IE   = 6;
  localparam int CB_EN   = 7;

  typedef struct packed {
    logic       en;
    logic       ie;
    logic       casc;
    logic [1:0] psc;
  } tmr_ctl_t;

  function automatic tmr_ctl_t decode_ctl(input logic [7:0] d);
    tmr_ctl_t c;
    c.en   = d[CB_EN];
    c.ie   = d[CB_IE];
    c.casc = d[CB_CASC];
    c.psc  = d[CB_PSC +: 2];
    return c;
  endfunction

endpackage

// File: rtl/tmr_prescaler.sv
module tmr_prescaler #(
  parameter int          PSC_W      = 10,
  parameter logic [15:0] PSC_SHIFTS = {4'd10, 4'd8, 4'd6, 4'd0}
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       clear,
  input  logic       run,
  input  logic [1:0] code,
  output logic       tick
);

  logic [PSC_W-1:0] div_q;
  logic [3:0]       shift;
  logic [PSC_W-1:0] mask;

  function automatic logic [PSC_W-1:0] low_mask(input logic [3:0] s);
    return PSC_W'((32'd1 << s) - 32'd1);
  endfunction

  assign shift = PSC_SHIFTS[{code, 2'b00} +: 4];
  assign mask  = low_mask(shift);
  assign tick  = run && ((div_q & mask) == mask);

  always_ff @(posedge clk) begin
    if (!rst_n)     div_q <= '0;
    else if (clear) div_q <= '0;
    else if (run)   div_q <= div_q + 1'b1;
  end

  AST_PSC_CLEARED: assert property (@(posedge clk) disable iff (!rst_n)
    clear |=> (div_q == '0)); // R3

endmodule

// File: rtl/tmr_unit.sv
module tmr_unit
  import tmr_pkg::*;
#(
  parameter int          CNT_W      = 16,
  parameter int          PSC_W      = 10,
  parameter logic [15:0] PSC_SHIFTS = {4'd10, 4'd8, 4'd6, 4'd0},
  parameter bit          CASC_OK    = 1'b1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             rld_we,
  input  logic             ctl_we,
  input  logic [CNT_W-1:0] wr_data,
  input  logic             ovf_in,
  output logic [CNT_W-1:0] cnt_o,
  output logic             ovf_o,
  output logic             irq_o
);

  tmr_ctl_t         ctl_q;
  tmr_ctl_t         ctl_d;
  logic [CNT_W-1:0] cnt_q;
  logic [CNT_W-1:0] rld_q;
  logic [CNT_W-1:0] cnt_nxt;
  logic             irq_q;
  logic             en_set;
  logic             casc_mode;
  logic             psc_tick;
  logic             step;

  // Adds one step; on carry out, the reload value absorbs the excess.
  function automatic logic [CNT_W:0] advance(input logic [CNT_W-1:0] c,
                                             input logic [CNT_W-1:0] r,
                                             input logic             s);
    logic [CNT_W:0] sum;
    sum = {1'b0, c} + {{CNT_W{1'b0}}, s};
    if (sum[CNT_W]) return {1'b1, r + sum[CNT_W-1:0]};
    else            return {1'b0, sum[CNT_W-1:0]};
  endfunction

  assign ctl_d     = decode_ctl(wr_data[7:0]);
  assign en_set    = ctl_we && ctl_d.en && !ctl_q.en;
  assign casc_mode = CASC_OK && ctl_q.casc;

  tmr_prescaler #(
    .PSC_W      (PSC_W),
    .PSC_SHIFTS (PSC_SHIFTS)
  ) u_psc (
    .clk   (clk),
    .rst_n (rst_n),
    .clear (en_set),
    .run   (ctl_q.en),
    .code  (ctl_q.psc),
    .tick  (psc_tick)
  );

  assign step             = ctl_q.en && (casc_mode ? ovf_in : psc_tick);
  assign {ovf_o, cnt_nxt} = advance(cnt_q, rld_q, step);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      ctl_q <= '0;
      rld_q <= '0;
      cnt_q <= '0;
      irq_q <= 1'b0;
    end else begin
      if (ctl_we) ctl_q <= ctl_d;
      if (rld_we) rld_q <= wr_data;
      cnt_q <= en_set ? rld_q : cnt_nxt;
      irq_q <= ovf_o && ctl_q.ie;
    end
  end

  assign cnt_o = cnt_q;
  assign irq_o = irq_q;

  AST_START_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
    en_set |=> (cnt_q == $past(rld_q))); // R3
  AST_SINGLE_STEP: assert property (@(posedge clk) disable iff (!rst_n)
    (ctl_q.en && !en_set && !ovf_o) |=>
      ((cnt_q == $past(cnt_q)) || (cnt_q == $past(cnt_q) + CNT_W'(1)))); // R4
  AST_WRAP_RELOAD: assert property (@(posedge clk) disable iff (!rst_n)
    ovf_o |=> (cnt_q == $past(rld_q))); // R5
  AST_IRQ_ON_WRAP: assert property (@(posedge clk) disable iff (!rst_n)
    ovf_o |=> (irq_o == $past(ctl_q.ie))); // R6
  AST_IRQ_CAUSE: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(irq_o) |-> $past(ovf_o)); // R6
  AST_CASC_WAIT: assert property (@(posedge clk) disable iff (!rst_n)
    (casc_mode && !ovf_in && !en_set) |=> $stable(cnt_q)); // R7
  AST_IDLE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (!ctl_q.en && !en_set) |=> $stable(cnt_q)); // R9

endmodule

// File: rtl/tmr_bank.sv
module tmr_bank #(
  parameter int          NUM_TMR    = 4,
  parameter int          CNT_W      = 16,
  parameter int          PSC_W      = 10,
  parameter logic [15:0] PSC_SHIFTS = {4'd10, 4'd8, 4'd6, 4'd0},
  localparam int         IDX_W      = $clog2(NUM_TMR)
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               wr_en,
  input  logic [IDX_W-1:0]   wr_idx,
  input  logic               wr_ctl,
  input  logic [CNT_W-1:0]   wr_data,
  input  logic [IDX_W-1:0]   rd_idx,
  output logic [CNT_W-1:0]   rd_count,
  output logic [NUM_TMR-1:0] irq
);

  logic [CNT_W-1:0]   cnt_arr [NUM_TMR];
  logic [NUM_TMR-1:0] ovf;

  for (genvar i = 0; i < NUM_TMR; i++) begin : g_tmr
    logic sel;
    logic chain_in;
    assign sel = wr_en && (wr_idx == IDX_W'(i));
    if (i == 0) begin : g_base
      assign chain_in = 1'b0;
    end else begin : g_link
      assign chain_in = ovf[i-1];
    end

    tmr_unit #(
      .CNT_W      (CNT_W),
      .PSC_W      (PSC_W),
      .PSC_SHIFTS (PSC_SHIFTS),
      .CASC_OK    (i != 0)
    ) u_tmr (
      .clk     (clk),
      .rst_n   (rst_n),
      .rld_we  (sel && !wr_ctl),
      .ctl_we  (sel && wr_ctl),
      .wr_data (wr_data),
      .ovf_in  (chain_in),
      .cnt_o   (cnt_arr[i]),
      .ovf_o   (ovf[i]),
      .irq_o   (irq[i])
    );
  end

  assign rd_count = cnt_arr[rd_idx];

  AST_RESET_QUIET: assert property (@(posedge clk)
    !rst_n |=> (irq == '0)); // R1

endmodule

// File: tb/sim_tmr_bank.sv
`timescale 1ns/1ps
module sim_tmr_bank;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        wr_en = 1'b0;
  logic [1:0]  wr_idx = '0;
  logic        wr_ctl = 1'b0;
  logic [15:0] wr_data = '0;
  logic [1:0]  rd_idx = '0;
  logic [15:0] rd_count;
  logic [3:0]  irq;

  int vectors = 0;
  int miscmp  = 0;
  int cyc     = 0;
  bit done    = 1'b0;

  typedef struct {
    int          sel;
    logic [15:0] ecnt;
    logic [3:0]  eirq;
    string       tag;
  } item_t;

  item_t sb[$];
  item_t it;

  tmr_bank u0 (
    .clk      (clk),
    .rst_n    (rst_n),
    .wr_en    (wr_en),
    .wr_idx   (wr_idx),
    .wr_ctl   (wr_ctl),
    .wr_data  (wr_data),
    .rd_idx   (rd_idx),
    .rd_count (rd_count),
    .irq      (irq)
  );

  always #4 clk = ~clk;

  always @(posedge clk) if (rst_n) cyc <= cyc + 1;

  // Count after n edges since enable: one step per 2^sh edges, wrapping to r.
  function automatic logic [15:0] mdl(input logic [15:0] r, input int sh, input int n);
    int per;
    per = 65536 - int'(r);
    return 16'(int'(r) + ((n >> sh) % per));
  endfunction

  // Monitor: pops one expected item per falling edge and compares.
  always @(negedge clk) begin
    #1;
    if (sb.size() > 0) begin
      it = sb.pop_front();
      vectors++;
      if (rd_count !== it.ecnt || irq !== it.eirq) begin
        miscmp++;
        $display("FAIL %s: timer %0d count=%h irq=%b, expected count=%h irq=%b",
                 it.tag, it.sel, rd_count, irq, it.ecnt, it.eirq);
      end
    end
  end

  task automatic wr(input int idx, input bit ctl, input logic [15:0] d);
    @(negedge clk);
    wr_en = 1'b1; wr_idx = 2'(idx); wr_ctl = ctl; wr_data = d;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic expect_at(input int tgt, input int sel, input logic [15:0] c,
                           input logic [3:0] q, input string tag);
    while (cyc < tgt) @(negedge clk);
    rd_idx = 2'(sel);
    sb.push_back('{sel, c, q, tag});
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      miscmp++;
      $display("FAIL watchdog: run incomplete, got %0d vectors, expected completion", vectors);
      $display("== %0d vectors applied, %0d miscompares ==", vectors, miscmp);
      $finish;
    end
  end

  initial begin
    int b;
    int b1;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    // R1 / R10: reset state on every read index
    for (int s = 0; s < 4; s++) expect_at(cyc + 1, s, 16'h0000, 4'b0000, "R1 R10");

    // Prescale code 0 with wrap and interrupt (R2 R3 R4 R5 R6)
    wr(0, 1'b0, 16'hFFF0);
    wr(0, 1'b1, 16'h00C0);
    b = cyc;
    expect_at(b,      0, 16'hFFF0, 4'b0000, "R3");
    expect_at(b + 5,  0, mdl(16'hFFF0, 0, 5), 4'b0000, "R4");
    expect_at(b + 15, 0, 16'hFFFF, 4'b0000, "R4");
    expect_at(b + 16, 0, 16'hFFF0, 4'b0001, "R5 R6");
    expect_at(b + 17, 0, 16'hFFF1, 4'b0000, "R6");
    wr(0, 1'b0, 16'h0000);                       // R9: new reload mid-run
    expect_at(b + 20, 0, 16'hFFF4, 4'b0000, "R9");
    expect_at(b + 32, 0, 16'h0000, 4'b0001, "R5 R9");
    wr(0, 1'b1, 16'h0000);                       // disable; edge b+34 still counts
    expect_at(b + 40, 0, 16'h0002, 4'b0000, "R9");

    // Divide by 64 (R4)
    wr(2, 1'b0, 16'h0000);
    wr(2, 1'b1, 16'h0081);
    b = cyc;
    expect_at(b + 63,  2, mdl(16'h0000, 6, 63),  4'b0000, "R4");
    expect_at(b + 64,  2, mdl(16'h0000, 6, 64),  4'b0000, "R4");
    expect_at(b + 200, 2, mdl(16'h0000, 6, 200), 4'b0000, "R4");

    // Divide by 1024, interrupt masked (R4 R5 R6)
    wr(3, 1'b0, 16'hFFFE);
    wr(3, 1'b1, 16'h0083);
    b = cyc;
    expect_at(b + 1023, 3, 16'hFFFE, 4'b0000, "R4");
    expect_at(b + 1024, 3, 16'hFFFF, 4'b0000, "R4");
    expect_at(b + 2048, 3, mdl(16'hFFFE, 10, 2048), 4'b0000, "R5 R6");
    wr(3, 1'b1, 16'h0000);

    // Cascade (R7 R8)
    wr(1, 1'b0, 16'hFFFE);
    wr(1, 1'b1, 16'h00C4);
    b1 = cyc;
    expect_at(b1 + 10, 1, 16'hFFFE, 4'b0000, "R7");
    wr(0, 1'b0, 16'hFFFC);
    wr(0, 1'b1, 16'h00C4);
    b = cyc;
    expect_at(b + 3, 0, 16'hFFFF, 4'b0000, "R8");
    expect_at(b + 4, 1, 16'hFFFF, 4'b0001, "R7");
    expect_at(b + 8, 1, 16'hFFFE, 4'b0011, "R7");
    expect_at(b + 9, 0, 16'hFFFD, 4'b0000, "R8");

    // Re-enable reloads and realigns the prescaler (R3)
    wr(0, 1'b1, 16'h0000);
    wr(0, 1'b1, 16'h00C1);
    b = cyc;
    expect_at(b,      0, 16'hFFFC, 4'b0000, "R3");
    expect_at(b + 63, 0, 16'hFFFC, 4'b0000, "R3");
    expect_at(b + 64, 0, 16'hFFFD, 4'b0000, "R3");

    repeat (3) @(negedge clk);
    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", vectors, miscmp);
    $finish;
  end

endmodule